// File: doc/BRIEF.md
# Branch Clock Gate Controller

This block controls a set of branch clocks that share one base clock. Each branch has a small register, reached over a simple single-cycle register port. Setting the branch's run bit opens its gate, which means its clock-enable output is asserted. Branch 0 is the bus branch for the group. The peripheral branches get their clock through it, so stopping branch 0 silences all of them.

Some branches are built with a divider, chosen by parameter. On those branches software can request divide-by-two. The enable output then pulses on every other base clock cycle. The request bit cannot be read back; a separate status bit shows whether halving is in effect.

Stopping a branch takes two writes. The first write arms the turn-off with the arm bit while run is still high. A later write clears run. A single-write stop is refused and recorded in a sticky error flag. The block also models the base clock being on or off, and it refuses register accesses while the base clock is off.

Top module: `ccu_branch_gate`

## Requirements
- R1: After reset, the branches marked essential (default: branches 0 and 1) read 0x00000001 and have their enable high. Every other branch reads 0x00000000 and has its enable low.
- R2: A write with bit 0 (run) set starts the branch. Its enable is high from the cycle after the write.
- R3: The read word holds run in bit 0, arm in bit 1 and divide status in bit 27. Every other bit reads 0, including bit 5 (divide request), which is write-only.
- R4: A write that clears run stops the branch only if arm (bit 1) was already set by an earlier write. The branch then reads run = 0 and its enable drops in the next cycle.
- R5: A write that clears run while arm is not already set leaves run at 1 and sets the sticky `seq_err` output. `seq_err` stays high until reset.
- R6: While `base_on` is low, every access gets an error response with read data 0, writes change nothing, and every enable is low.
- R7: While the bus branch (index 0) is stopped, every peripheral branch has its enable low, even if its own run bit is set. Restarting branch 0 restores their enables.
- R8: On a divider branch, writing bit 5 = 1 sets the status bit (bit 27) within two cycles. The status changes only at the end of a two-cycle phase. While the status is set, the enable toggles every cycle. Writing bit 5 = 0 returns the branch to a steady enable.
- R9: On a branch without a divider, bit 5 has no effect: the status bit reads 0 and the enable stays continuously high while the branch runs.
- R10: An access to an index at or above the branch count gets an error response with read data 0.
- R11: Every request gets its response (`rsp_valid`) in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_on | input | 1 | Base clock is running |
| bus_req | input | 1 | Access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Branch index |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 32 | Read data |
| clk_en | output | NUM_BR | Per-branch clock enable |
| seq_err | output | 1 | Sticky bad-turn-off flag |

## Verification
The bench tries a single-write turn-off. A design that honours it would drop the enable and leave `seq_err` low. It then runs the correct arm-then-clear sequence, which a design that keys on the wrong bit would refuse.

It stops the bus branch while children are running. A design missing the hierarchy would keep child enables high. It writes the divide request to divider and non-divider branches. That exposes a status bit that reads back the request, an enable that does not alternate, or a non-divider branch that halves.

Accesses with the base clock off and with out-of-range indices must return an error and zero data and must leave state untouched. Mistakes there show up as a changed read-back afterwards.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
    localparam int BIT_RUN     = 0;
    localparam int BIT_ARM     = 1;
    localparam int BIT_DIVREQ  = 5;
    localparam int BIT_DIVSTAT = 27;

    typedef struct packed {
        logic run;
        logic arm;
        logic div_req;
        logic div_stat;
    } br_state_t;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] rdata;
    } rsp_t;
endpackage

// File: rtl/ccu_phase_gen.sv
module ccu_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic ph_end
);
    logic ph_d, ph_q;

    always_comb begin
        ph_d = ~ph_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ph_d;
    end

    assign ph_end = ph_q;
endmodule

// File: rtl/ccu_branch.sv
module ccu_branch
    import ccu_pkg::*;
#(
    parameter bit HAS_DIV   = 1'b0,
    parameter bit ESSENTIAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_run,
    input  logic wr_arm,
    input  logic wr_div,
    input  logic ph_end,
    output logic run,
    output logic arm,
    output logic div_stat,
    output logic seq_viol
);
    br_state_t st_d, st_q;
    logic      viol_d;
    logic      div_req_in;

    generate
        if (HAS_DIV) begin : g_div
            assign div_req_in = wr_div;
        end else begin : g_nodiv
            logic unused_div;
            assign unused_div = wr_div;
            assign div_req_in = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        viol_d = 1'b0;
        if (wr_en) begin
            st_d.arm     = wr_arm;
            st_d.div_req = div_req_in;
            if (wr_run) begin
                st_d.run = 1'b1;
            end else if (st_q.run && !st_q.arm) begin
                viol_d = 1'b1;
            end else begin
                st_d.run = 1'b0;
            end
        end
        if (ph_end) begin
            st_d.div_stat = st_q.div_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: ESSENTIAL, arm: 1'b0, div_req: 1'b0, div_stat: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run      = st_q.run;
    assign arm      = st_q.arm;
    assign div_stat = st_q.div_stat;
    assign seq_viol = viol_d;

    a_r4_stop_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> $past(st_q.arm));

    a_r8_stat_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.div_stat) |-> $past(ph_end));

    a_r5_viol_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        seq_viol |=> st_q.run);
endmodule

// File: rtl/ccu_bus_port.sv
module ccu_bus_port
    import ccu_pkg::*;
#(
    parameter int NUM_BR = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_on,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       rd_word [NUM_BR],
    output logic [NUM_BR-1:0] wr_sel,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);
    localparam int IDX_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1;

    rsp_t             rsp_d, rsp_q;
    logic             hit;
    logic             ok;
    logic [IDX_W-1:0] idx;

    always_comb begin
        hit    = ({1'b0, addr} < (ADDR_W+1)'(NUM_BR));
        ok     = req && base_on && hit;
        idx    = addr[IDX_W-1:0];
        wr_sel = '0;
        if (ok && we) wr_sel[idx] = 1'b1;
        rsp_d.valid = req;
        rsp_d.err   = req && !ok;
        rsp_d.rdata = (ok && !we) ? rd_word[idx] : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req));

    a_r6_off_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !base_on) |=> (rsp_err && rsp_rdata == 32'h0));

    a_r10_range_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !hit) |=> rsp_err);
endmodule

// File: rtl/ccu_branch_gate.sv
module ccu_branch_gate
    import ccu_pkg::*;
#(
    parameter int              NUM_BR   = 8,
    parameter int              ADDR_W   = 4,
    parameter logic [NUM_BR-1:0] DIV_MASK = 8'b1100_0000,
    parameter logic [NUM_BR-1:0] ESS_MASK = 8'b0000_0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_on,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [NUM_BR-1:0] clk_en,
    output logic              seq_err
);
    logic              ph_end;
    logic [NUM_BR-1:0] wr_sel, run, arm, stat, viol;
    logic [31:0]       rd_word [NUM_BR];
    logic              err_d, err_q;
    logic              unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:6], bus_wdata[4:2]};

    ccu_phase_gen u_phase (.clk(clk), .rst_n(rst_n), .ph_end(ph_end));

    ccu_bus_port #(.NUM_BR(NUM_BR), .ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n), .base_on(base_on),
        .req(bus_req), .we(bus_we), .addr(bus_addr), .rd_word(rd_word),
        .wr_sel(wr_sel), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    for (genvar i = 0; i < NUM_BR; i++) begin : g_br
        ccu_branch #(.HAS_DIV(DIV_MASK[i]), .ESSENTIAL(ESS_MASK[i])) u_br (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[i]),
            .wr_run(bus_wdata[BIT_RUN]), .wr_arm(bus_wdata[BIT_ARM]),
            .wr_div(bus_wdata[BIT_DIVREQ]), .ph_end(ph_end),
            .run(run[i]), .arm(arm[i]), .div_stat(stat[i]), .seq_viol(viol[i])
        );

        always_comb begin
            rd_word[i]              = 32'h0;
            rd_word[i][BIT_RUN]     = run[i];
            rd_word[i][BIT_ARM]     = arm[i];
            rd_word[i][BIT_DIVSTAT] = stat[i];
        end

        if (i == 0) begin : g_bus
            assign clk_en[i] = base_on & run[0];
        end else begin : g_leaf
            assign clk_en[i] = base_on & run[0] & run[i] & (~stat[i] | ph_end);
        end
    end

    always_comb begin
        err_d = err_q | (|viol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign seq_err = err_q;

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    a_r7_bus_gates_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en[0] |-> (clk_en[NUM_BR-1:1] == '0));

    a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !base_on |-> (clk_en == '0));
endmodule

// File: tb/ccu_branch_gate_tb.sv
module ccu_branch_gate_tb;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_on = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid, rsp_err, seq_err;
    logic [31:0] rsp_rdata;
    logic [NB-1:0] clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [32:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    ccu_branch_gate u_dut (
        .clk(clk), .rst_n(rst_n), .base_on(base_on),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .clk_en(clk_en), .seq_err(seq_err)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 64'd1, 64'd0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {31'd0, rsp_err, rsp_rdata}, {31'd0, e});
            end
        end
    end

    task automatic access(input bit we, input logic [3:0] a, input logic [31:0] d,
                          input bit e_err, input logic [31:0] e_data, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        exp_q.push_back({e_err, e_data});
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        check("R11 response next cycle", {63'd0, rsp_valid}, 64'd1);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check_en(string tag, logic [NB-1:0] e);
        check(tag, {56'd0, clk_en}, {56'd0, e});
    endtask

    task automatic check_toggle(string tag, int b, bit expect_toggle);
        logic prev;
        prev = clk_en[b];
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (expect_toggle) check(tag, {63'd0, clk_en[b]}, {63'd0, ~prev});
            else               check(tag, {63'd0, clk_en[b]}, 64'd1);
            prev = clk_en[b];
        end
    endtask

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check_en("R1 reset enables", 8'b0000_0011);
        check("R1 seq_err reset", {63'd0, seq_err}, 64'd0);
        access(0, 4'd0, 0, 0, 32'h1, "R1 read bus branch");
        access(0, 4'd1, 0, 0, 32'h1, "R1 read essential");
        access(0, 4'd2, 0, 0, 32'h0, "R1 read stopped branch");

        // R2 start a branch
        access(1, 4'd2, 32'h1, 0, 32'h0, "R2 write run");
        check_en("R2 enable after run", 8'b0000_0111);

        // R5 single-write stop is refused
        access(1, 4'd2, 32'h0, 0, 32'h0, "R5 bad stop write");
        check("R5 seq_err set", {63'd0, seq_err}, 64'd1);
        check_en("R5 still running", 8'b0000_0111);
        access(0, 4'd2, 0, 0, 32'h1, "R5 run kept");

        // R4 two-step stop
        access(1, 4'd2, 32'h3, 0, 32'h0, "R4 arm write");
        access(0, 4'd2, 0, 0, 32'h3, "R3 R4 arm readback");
        access(1, 4'd2, 32'h0, 0, 32'h0, "R4 clear run");
        check_en("R4 stopped", 8'b0000_0011);
        access(0, 4'd2, 0, 0, 32'h0, "R4 run cleared");
        check("R5 seq_err sticky", {63'd0, seq_err}, 64'd1);

        // R9 divide request on a non-divider branch
        access(1, 4'd3, 32'h23, 0, 32'h0, "R9 write div on plain");
        idle(3);
        access(0, 4'd3, 0, 0, 32'h3, "R3 R9 div bit hidden, no status");
        check_toggle("R9 steady enable", 3, 0);

        // R8 divide on a divider branch
        access(1, 4'd6, 32'h21, 0, 32'h0, "R8 write div");
        idle(3);
        access(0, 4'd6, 0, 0, 32'h0800_0001, "R3 R8 status set");
        check_toggle("R8 alternating enable", 6, 1);
        access(1, 4'd6, 32'h1, 0, 32'h0, "R8 clear div");
        idle(3);
        access(0, 4'd6, 0, 0, 32'h1, "R8 status cleared");
        check_toggle("R8 steady again", 6, 0);

        // R7 bus branch gates leaves
        access(1, 4'd0, 32'h3, 0, 32'h0, "R7 arm bus");
        access(1, 4'd0, 32'h2, 0, 32'h0, "R7 stop bus");
        check_en("R7 all leaves off", 8'b0000_0000);
        access(0, 4'd3, 0, 0, 32'h3, "R7 leaf run kept");
        access(1, 4'd0, 32'h1, 0, 32'h0, "R7 restart bus");
        check_en("R7 leaves restored", 8'b0100_1011);

        // R6 base clock off
        @(negedge clk);
        base_on = 1'b0;
        #1;
        check_en("R6 enables off", 8'b0000_0000);
        access(0, 4'd1, 0, 1, 32'h0, "R6 read refused");
        access(1, 4'd3, 32'h0, 1, 32'h0, "R6 write refused");
        @(negedge clk);
        base_on = 1'b1;
        access(0, 4'd3, 0, 0, 32'h3, "R6 write had no effect");

        // R10 out of range
        access(0, 4'd9, 0, 1, 32'h0, "R10 read out of range");
        access(1, 4'd8, 32'h1, 1, 32'h0, "R10 write out of range");
        check_en("R10 no change", 8'b0100_1011);

        idle(2);
        check("R11 scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule